// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the target side of a two-wire serial memory with byte-wide storage. It takes the clock and data lines from the bus through a short synchroniser, recognises the bus framing events, and answers only when the first byte after a framing open carries the memory device-type code and a select code equal to three strap inputs. A write transaction delivers a two-byte memory pointer and then data bytes that land in consecutive locations. A read transaction streams bytes from the current pointer for as long as the bus master acknowledges them.

The data line is never driven high. The block only asserts an active-low pull enable, and the surrounding pad and pull-up form the open-drain line. Any framing open or close event aborts whatever is in progress. The pointer width is a parameter. Setting `ADDR_W` to 13 gives the 8K x 8 organisation, and the default is kept smaller so the elaborated array stays modest.

Top module: `twMemSlave`

## Requirements
- R1: A falling data line while the clock line is high (an open event) aborts any transfer in progress, including one in mid-byte, and the next eight bits are taken as a device-select byte.
- R2: A rising data line while the clock line is high (a close event) releases the data line and returns the block to idle. A partly received data byte is discarded, and bytes clocked after the close event are not acknowledged.
- R3: A device-select byte whose bits 7..4 are 1010 and whose bits 3..1 equal `selPins` is acknowledged by pulling the data line low during the ninth clock. Bit 0 of that byte chooses a read (1) or a write (0).
- R4: A device-select byte that fails either field is not acknowledged. All later bytes are neither acknowledged nor stored until the next open event.
- R5: After a write selection, the next two bytes form the pointer, high byte first, and only the low `ADDR_W` bits are kept. Every further byte is stored at the pointer and acknowledged.
- R6: A read sends the byte at the pointer most significant bit first and sends the next byte whenever the master acknowledges. A master no-acknowledge ends the read, and the data line stays released for the clocks that follow.
- R7: The pointer advances by one after every byte stored or sent and wraps from its all-ones value to zero. A read that is not preceded by a pointer write starts at the current pointer.
- R8: The pull enable changes only while the synchronised clock line is low, apart from the release caused by an open or close event.
- R9: Reset releases the data line and sets the pointer to zero. Reset does not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| selPins | input | 3 | Strap value the select field must equal |
| sdaOe | output | 1 | Active-high enable that pulls the data line low |

## Verification
The bench builds the block with `ADDR_W` set to 8 and a two-stage synchroniser. With that setting, the whole 256-byte array can be filled in a single burst at the start, so every later read has a known expected value. The wrap from 0xFF to 0x00 also falls within a few bytes of a chosen pointer. The select strap is fixed at 101, so both a wrong device-type code and a wrong select code can be driven against it. A 13-bit pointer uses the same logic with a wider slice and a larger array.

// File: rtl/twMemPkg.sv
package twMemPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR_HI,
    ST_PTR_LO,
    ST_WDATA,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX
  } twState_t;

  typedef enum logic [1:0] {
    DRV_REL,
    DRV_ACK,
    DRV_BIT
  } driveMode_t;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
  } twStrobes_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twMemDatapath.sv
module twMemDatapath
  import twMemPkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  twStrobes_t        strb,
  input  driveMode_t        mode,
  output logic              sclLevel,
  output logic              sdaLevel,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] curAddr,
  output logic              sdaOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [SYNC_LEN-1:0] sclPipe, sdaPipe;
  logic                sclPrev, sdaPrev;
  logic [7:0]          ptrHi;
  logic [7:0]          txShift;
  logic [15:0]         ptrCat;
  logic [7:0]          mem [DEPTH];

  // Line synchronisers; idle bus level is high.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_LEN-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_LEN-2:0], sdaIn};
      sclPrev <= sclLevel;
      sdaPrev <= sdaLevel;
    end
  end

  assign sclLevel = sclPipe[SYNC_LEN-1];
  assign sdaLevel = sdaPipe[SYNC_LEN-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startEv  = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopEv   = sclLevel & sclPrev & ~sdaPrev & sdaLevel;

  assign ptrCat = {ptrHi, rxByte};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      ptrHi   <= '0;
      txShift <= '0;
      curAddr <= '0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaLevel};
      if (strb.loadHi)  ptrHi  <= rxByte;
      if (strb.loadTx)       txShift <= mem[curAddr];
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (strb.loadLo)        curAddr <= ptrCat[ADDR_W-1:0];
      else if (strb.incAddr)  curAddr <= curAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeMem) mem[curAddr] <= rxByte;
  end

  assign sdaOe = (mode == DRV_ACK) | ((mode == DRV_BIT) & ~txShift[7]);

endmodule

// File: rtl/twMemControl.sv
module twMemControl
  import twMemPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sdaLevel,
  input  logic [7:0] rxByte,
  input  logic [2:0] selPins,
  output twStrobes_t strb,
  output driveMode_t mode,
  output logic       inIdle
);

  twState_t   st, afterAck, nextAfter;
  logic [3:0] bitCnt;
  logic       masterAck;
  logic       devHit, rxState, byteEnd, noEv;

  assign noEv    = ~startEv & ~stopEv;
  assign rxState = (st == ST_DEV) | (st == ST_PTR_HI) | (st == ST_PTR_LO) | (st == ST_WDATA);
  assign byteEnd = sclFall & (bitCnt == 4'd8);
  assign devHit  = (rxByte[7:4] == DEV_TYPE) & (rxByte[3:1] == selPins);
  assign inIdle  = (st == ST_IDLE);

  always_comb begin
    case (st)
      ST_DEV:    nextAfter = rxByte[0] ? ST_TX : ST_PTR_HI;
      ST_PTR_HI: nextAfter = ST_PTR_LO;
      default:   nextAfter = ST_WDATA;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.shiftIn  = noEv & rxState & sclRise;
    strb.loadHi   = noEv & (st == ST_PTR_HI) & byteEnd;
    strb.loadLo   = noEv & (st == ST_PTR_LO) & byteEnd;
    strb.writeMem = noEv & (st == ST_WDATA) & byteEnd;
    strb.loadTx   = noEv & sclFall &
                    (((st == ST_ACK_RX) & (afterAck == ST_TX)) | ((st == ST_ACK_TX) & masterAck));
    strb.shiftTx  = noEv & (st == ST_TX) & sclFall & (bitCnt != 4'd8);
    strb.incAddr  = strb.writeMem | strb.loadTx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      afterAck  <= ST_IDLE;
      mode      <= DRV_REL;
      bitCnt    <= '0;
      masterAck <= 1'b0;
    end else if (startEv) begin
      st     <= ST_DEV;
      mode   <= DRV_REL;
      bitCnt <= '0;
    end else if (stopEv) begin
      st     <= ST_IDLE;
      mode   <= DRV_REL;
      bitCnt <= '0;
    end else begin
      case (st)
        ST_DEV, ST_PTR_HI, ST_PTR_LO, ST_WDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteEnd) begin
            bitCnt <= '0;
            if ((st == ST_DEV) && !devHit) begin
              st <= ST_IDLE;
            end else begin
              st       <= ST_ACK_RX;
              mode     <= DRV_ACK;
              afterAck <= nextAfter;
            end
          end
        end
        ST_ACK_RX: begin
          if (sclFall) begin
            st   <= afterAck;
            mode <= (afterAck == ST_TX) ? DRV_BIT : DRV_REL;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteEnd) begin
            bitCnt <= '0;
            mode   <= DRV_REL;
            st     <= ST_ACK_TX;
          end
        end
        ST_ACK_TX: begin
          if (sclRise) begin
            masterAck <= ~sdaLevel;
          end else if (sclFall) begin
            st   <= masterAck ? ST_TX : ST_IDLE;
            mode <= masterAck ? DRV_BIT : DRV_REL;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twMemSlave.sv
module twMemSlave
  import twMemPkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] selPins,
  output logic       sdaOe
);

  twStrobes_t        strb;
  driveMode_t        mode;
  logic              sclLevel, sdaLevel, sclRise, sclFall, startEv, stopEv, inIdle;
  logic              incAddrW;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] curAddr;

  assign incAddrW = strb.incAddr;

  twMemDatapath #(.ADDR_W(ADDR_W), .SYNC_LEN(SYNC_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strb(strb), .mode(mode),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .rxByte(rxByte), .curAddr(curAddr),
    .sdaOe(sdaOe)
  );

  twMemControl u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaLevel(sdaLevel), .rxByte(rxByte),
    .selPins(selPins), .strb(strb), .mode(mode), .inIdle(inIdle)
  );

endmodule

// File: rtl/twMemChecker.sv
module twMemChecker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              sclLevel,
  input logic              startEv,
  input logic              stopEv,
  input logic              inIdle,
  input logic              incAddr,
  input logic [ADDR_W-1:0] curAddr
);

  p_open_releases_r1: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaOe);

  p_close_idles_r2: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (!sdaOe && inIdle));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    inIdle |-> !sdaOe);

  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (incAddr && (curAddr == {ADDR_W{1'b1}})) |=> (curAddr == '0));

  p_oe_clock_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && sclLevel) |-> ($past(startEv) || $past(stopEv)));

endmodule

bind twMemSlave twMemChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclLevel(sclLevel),
  .startEv(startEv), .stopEv(stopEv), .inIdle(inIdle),
  .incAddr(incAddrW), .curAddr(curAddr)
);

// File: tb/tb_twMemSlave.sv
module tb_twMemSlave;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int Q          = 5;
  localparam int MAX_CYC    = 190000;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mLow = 1'b0;
  logic sdaOe;
  wire  sdaBus = ~(mLow | sdaOe);

  int checks = 0;
  int errors = 0;
  int r8Viol = 0;
  bit done = 1'b0;

  logic [7:0] refMem [DEPTH];
  int refAddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twMemSlave #(.ADDR_W(ADDR_W), .SYNC_LEN(2)) dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .selPins(SEL), .sdaOe(sdaOe)
  );

  // R8 monitor: the pull enable must hold while the clock line stays high.
  logic prevOe = 1'b0;
  logic prevScl = 1'b1;
  always @(negedge clk) begin
    if (rstN && mScl && prevScl && (sdaOe !== prevOe)) r8Viol++;
    prevOe  = sdaOe;
    prevScl = mScl;
  end

  function automatic logic [7:0] devByte(input logic [3:0] kind, input logic [2:0] sel, input bit rd);
    return {kind, sel, rd};
  endfunction

  function automatic int nextPtr(input int a);
    return (a + 1) % DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busOpen();
    mLow = 1'b0; waitQ(1);
    mScl = 1'b1; waitQ(1);
    mLow = 1'b1; waitQ(1);
    mScl = 1'b0; waitQ(1);
  endtask

  task automatic busClose();
    mLow = 1'b1; waitQ(1);
    mScl = 1'b1; waitQ(1);
    mLow = 1'b0; waitQ(1);
  endtask

  task automatic putBit(input bit b);
    mLow = ~b; waitQ(1);
    mScl = 1'b1; waitQ(2);
    mScl = 1'b0; waitQ(1);
  endtask

  task automatic getBit(output bit b);
    mLow = 1'b0; waitQ(1);
    mScl = 1'b1; waitQ(1);
    b = sdaBus; waitQ(1);
    mScl = 1'b0; waitQ(1);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(~ackIt);
  endtask

  task automatic setPtr(input int a);
    bit ak;
    sendByte(devByte(4'b1010, SEL, 1'b0), ak); chk(ak, "R3 write select ack", ak, 1);
    sendByte(8'(a >> 8), ak);                   chk(ak, "R5 pointer high ack", ak, 1);
    sendByte(8'(a), ak);                        chk(ak, "R5 pointer low ack", ak, 1);
    refAddr = a % DEPTH;
  endtask

  task automatic doWrite(input int a, input int n);
    bit ak;
    logic [7:0] d;
    busOpen();
    setPtr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sendByte(d, ak);
      chk(ak, "R5 data byte ack", ak, 1);
      refMem[refAddr] = d;
      refAddr = nextPtr(refAddr);
    end
    busClose();
  endtask

  task automatic readBurst(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, v);
      chk(v === refMem[refAddr], req, v, refMem[refAddr]);
      refAddr = nextPtr(refAddr);
    end
  endtask

  task automatic doRead(input bit usePtr, input int a, input int n, input string req);
    bit ak;
    busOpen();
    if (usePtr) begin
      setPtr(a);
      busOpen();
    end
    sendByte(devByte(4'b1010, SEL, 1'b1), ak);
    chk(ak, "R3 read select ack", ak, 1);
    readBurst(n, req);
    busClose();
  endtask

  initial begin
    bit ak, b;
    int a, n;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(sdaOe == 1'b0, "R9 released in reset", sdaOe, 0);
    rstN = 1'b1;
    waitQ(2);
    chk(sdaOe == 1'b0, "R9 released after reset", sdaOe, 0);

    // Fill the whole array in one burst; the final byte wraps the pointer (R7).
    doWrite(0, DEPTH);
    doRead(1'b1, 0, 4, "R6 sequential read after fill");

    // Wrap across the top of the array.
    doWrite(DEPTH - 2, 4);
    doRead(1'b1, DEPTH - 2, 4, "R7 read across wrap");
    doRead(1'b0, 0, 2, "R7 current pointer read");

    // Pointer high bits beyond ADDR_W are discarded.
    doWrite(16'h3A10, 1);
    doRead(1'b1, 16'h0010, 1, "R5 pointer truncation");

    // Wrong device-type code and wrong select code.
    busOpen();
    sendByte(devByte(4'b1011, SEL, 1'b0), ak);
    chk(!ak, "R4 wrong type not acked", ak, 0);
    sendByte(8'h00, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    sendByte(8'h20, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    sendByte(8'h55, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    busClose();
    busOpen();
    sendByte(devByte(4'b1010, 3'b100, 1'b0), ak);
    chk(!ak, "R4 wrong select not acked", ak, 0);
    sendByte(8'h00, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    sendByte(8'h21, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    sendByte(8'hAA, ak); chk(!ak, "R4 later byte ignored", ak, 0);
    busClose();
    doRead(1'b1, 16'h0020, 2, "R4 memory untouched");

    // Close event in the middle of a data byte.
    busOpen();
    setPtr(16'h0040);
    for (int i = 0; i < 4; i++) putBit(~refMem[8'h40][7 - i]);
    busClose();
    chk(sdaOe == 1'b0, "R2 released after close", sdaOe, 0);
    sendByte(8'h5A, ak);
    chk(!ak, "R2 no ack after close", ak, 0);
    busClose();
    doRead(1'b1, 16'h0040, 1, "R2 partial byte discarded");

    // Open event inside a pointer byte; read continues at the old pointer.
    doRead(1'b1, 16'h0070, 1, "R6 pointer set");
    busOpen();
    sendByte(devByte(4'b1010, SEL, 1'b0), ak);
    chk(ak, "R3 write select ack", ak, 1);
    putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busOpen();
    sendByte(devByte(4'b1010, SEL, 1'b1), ak);
    chk(ak, "R1 select after open event", ak, 1);
    readBurst(2, "R1 read after abort");
    // After the master no-acknowledge the line must stay released.
    for (int i = 0; i < 9; i++) begin
      getBit(b);
      chk(b == 1'b1, "R6 released after nack", b, 1);
    end
    busClose();

    // Constrained random writes and reads.
    for (int t = 0; t < 14; t++) begin
      a = int'($urandom % DEPTH);
      n = 1 + int'($urandom % 6);
      doWrite(a, n);
      doRead(1'b1, a, n, "R5 random write readback");
      doRead(1'b0, 0, 1 + int'($urandom % 3), "R7 random current read");
    end

    // Reset restores pointer zero and keeps the contents.
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    refAddr = 0;
    waitQ(2);
    doRead(1'b0, 0, 2, "R9 pointer zero after reset");

    chk(r8Viol == 0, "R8 enable steady while clock high", r8Viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule